// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim and Completion

This block collects level-sensitive interrupt inputs from up to 31 peripheral sources and distributes them to a small number of processor contexts. Each source has a programmable priority. Each context has its own enable mask and a priority threshold. A context's interrupt line is raised while at least one source is pending, enabled for that context, and ranked strictly above the context's threshold.

Software services an interrupt in two steps through one register per context. A read of that register returns the identifier of the best eligible source and takes it out of the pending set. The source then stays blocked until software writes the same identifier back to the same register. The register port is a plain 32-bit bus with a valid strobe and a write flag. Read data is registered and appears in the cycle after the request.

Top module: `intc_core`

## Requirements
- R1: Source n (1..NSRC) has a priority register at byte offset 4·n. Only the low 3 bits are stored, and the upper bits read as zero. A priority of 0 means the source can never be selected.
- R2: Context c has an enable word at byte offset 0x2000 + 0x80·c. Bit n of that word enables source n. Bit 0 always reads as zero and ignores writes.
- R3: Context c has a threshold register at byte offset 0x200000 + 0x1000·c, holding 3 bits, with the upper bits reading as zero. The same context's claim/complete register is at that address plus 4. Read data is valid in the cycle after the read request.
- R4: irq_o[c] is registered. It is high in the cycle after one where at least one source is pending, enabled for c, and has a priority strictly greater than c's threshold. A priority equal to the threshold does not qualify.
- R5: A claim read returns the eligible source with the highest priority, choosing the lowest identifier on a tie. It returns 0 when no source is eligible.
- R6: A claimed source loses its pending state at once. It raises no request and cannot be claimed again, even with its input held high, until it is completed.
- R7: A write of identifier n to a context's claim/complete register releases source n only if n is in flight and enabled for that context. Any other completion write has no effect.
- R8: A source whose input is still high when it is completed becomes pending again one cycle later and can be claimed again.
- R9: After reset, every priority, enable, threshold, pending and in-flight bit is zero, every irq_o bit is low, and a claim read returns 0.
- R10: A single-cycle pulse on a source input is latched as pending and stays pending until the source is claimed.
- R11: Source identifier 0 does not exist. Its priority and enable bits read as zero, and it is never pending or in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_lvl | input | NSRC | Level interrupt inputs; bit n is source n (n = 1..NSRC) |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 22 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | NCTX | Interrupt request per context |

## Verification
The interesting collision is a claim read that lands in the same cycle as a new source input rising. The input may belong to a higher-priority source than the one being claimed. The bench first leaves one source pending, then issues the claim read and raises the higher-ranked input in the same clock. It expects the claim to return the source that was already pending, because the new input only becomes pending at that edge. A second claim must then return the late source.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
   localparam int ADDR_W = 22;
   localparam int DATA_W = 32;
   localparam logic [8:0] PAGE_PRIO = 9'd0;
   localparam logic [8:0] PAGE_EN   = 9'd2;
   localparam logic [9:0] SLOT_THR  = 10'd0;
   localparam logic [9:0] SLOT_CLM  = 10'd1;
endpackage

// File: rtl/intc_gate.sv
`timescale 1ns/1ps
module intc_gate #(
   parameter int NSRC = 31,
   parameter int IDW  = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC:0]   lvl,
   input  logic            claim_vld,
   input  logic [IDW-1:0]  claim_id,
   input  logic            done_vld,
   input  logic [IDW-1:0]  done_id,
   output logic [NSRC:0]   pend,
   output logic [NSRC:0]   busy
);
   assign pend[0] = 1'b0;
   assign busy[0] = 1'b0;

   for (genvar s = 1; s <= NSRC; s++) begin : g_src
      logic take, fin, p_q, b_q;
      assign take = claim_vld && (claim_id == IDW'(s));
      assign fin  = done_vld  && (done_id  == IDW'(s));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_q <= 1'b0;
            b_q <= 1'b0;
         end else if (take) begin
            p_q <= 1'b0;
            b_q <= 1'b1;
         end else begin
            if (fin) b_q <= 1'b0;
            if (lvl[s] && !b_q) p_q <= 1'b1;
         end
      end
      assign pend[s] = p_q;
      assign busy[s] = b_q;
   end
endmodule

// File: rtl/intc_pick.sv
`timescale 1ns/1ps
module intc_pick #(
   parameter int NSRC = 31,
   parameter int PW   = 3,
   parameter int IDW  = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NSRC:0]          pend,
   input  logic [NSRC:0]          en,
   input  logic [NSRC:0][PW-1:0]  prio,
   input  logic [PW-1:0]          thr,
   output logic [IDW-1:0]         best_id,
   output logic                   irq_o
);
   logic [PW-1:0] best_p;

   // Linear scan: strict '>' against the running best keeps the lowest ID on ties.
   always_comb begin
      best_id = '0;
      best_p  = '0;
      for (int s = 1; s <= NSRC; s++) begin
         if (pend[s] && en[s] && (prio[s] > thr) && (prio[s] > best_p)) begin
            best_id = IDW'(s);
            best_p  = prio[s];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= (best_id != '0);
   end
endmodule

// File: rtl/intc_regbank.sv
`timescale 1ns/1ps
module intc_regbank
   import intc_pkg::*;
#(
   parameter int NSRC = 31,
   parameter int NCTX = 2,
   parameter int PW   = 3,
   parameter int IDW  = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_valid,
   input  logic                          bus_write,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [DATA_W-1:0]             bus_wdata,
   output logic [DATA_W-1:0]             bus_rdata,
   input  logic [NCTX-1:0][IDW-1:0]      best_id,
   input  logic [NSRC:0]                 busy,
   output logic [NSRC:0][PW-1:0]         prio_q,
   output logic [NCTX-1:0][NSRC:0]       en_q,
   output logic [NCTX-1:0][PW-1:0]       thr_q,
   output logic                          claim_vld,
   output logic [IDW-1:0]                claim_id,
   output logic                          done_vld,
   output logic [IDW-1:0]                done_id
);
   logic          rd, wr;
   logic [8:0]    page;
   logic [9:0]    slot;
   logic          in_ctx, in_prio, in_en;
   logic          prio_ok;
   logic [IDW-1:0] pidx, wid;
   logic          wid_ok;
   logic [NCTX-1:0] hit_en, hit_thr, hit_clm;
   logic [DATA_W-1:0] rmux;

   assign rd      = bus_valid && !bus_write;
   assign wr      = bus_valid &&  bus_write;
   assign page    = bus_addr[20:12];
   assign slot    = bus_addr[11:2];
   assign in_ctx  = bus_addr[21];
   assign in_prio = !in_ctx && (page == PAGE_PRIO);
   assign in_en   = !in_ctx && (page == PAGE_EN);
   assign prio_ok = in_prio && (slot <= 10'(NSRC));
   assign pidx    = slot[IDW-1:0];
   assign wid     = bus_wdata[IDW-1:0];
   assign wid_ok  = (bus_wdata <= DATA_W'(NSRC)) && (wid != '0);

   assign prio_q[0] = '0;
   for (genvar s = 1; s <= NSRC; s++) begin : g_prio
      logic [PW-1:0] p_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) p_q <= '0;
         else if (wr && prio_ok && pidx == IDW'(s)) p_q <= bus_wdata[PW-1:0];
      end
      assign prio_q[s] = p_q;
   end

   for (genvar c = 0; c < NCTX; c++) begin : g_ctx
      logic [NSRC:1] e_q;
      logic [PW-1:0] t_q;
      assign hit_en[c]  = in_en && (bus_addr[11:7] == 5'(c)) && (bus_addr[6:2] == 5'd0);
      assign hit_thr[c] = in_ctx && (page == 9'(c)) && (slot == SLOT_THR);
      assign hit_clm[c] = in_ctx && (page == 9'(c)) && (slot == SLOT_CLM);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            e_q <= '0;
            t_q <= '0;
         end else if (wr) begin
            if (hit_en[c])  e_q <= bus_wdata[NSRC:1];
            if (hit_thr[c]) t_q <= bus_wdata[PW-1:0];
         end
      end
      assign en_q[c]  = {e_q, 1'b0};
      assign thr_q[c] = t_q;
   end

   always_comb begin
      claim_id = '0;
      done_vld = 1'b0;
      rmux     = '0;
      if (prio_ok) rmux = DATA_W'(prio_q[pidx]);
      for (int c = 0; c < NCTX; c++) begin
         if (hit_en[c])  rmux = DATA_W'(en_q[c]);
         if (hit_thr[c]) rmux = DATA_W'(thr_q[c]);
         if (hit_clm[c]) begin
            claim_id = best_id[c];
            rmux     = DATA_W'(best_id[c]);
            if (wr && wid_ok && busy[wid] && en_q[c][wid]) done_vld = 1'b1;
         end
      end
   end

   assign claim_vld = rd && (claim_id != '0);
   assign done_id   = wid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bus_rdata <= '0;
      else if (rd) bus_rdata <= rmux;
   end
endmodule

// File: rtl/intc_core.sv
`timescale 1ns/1ps
module intc_core
   import intc_pkg::*;
#(
   parameter int NSRC = 31,
   parameter int NCTX = 2,
   parameter int PW   = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NSRC:1]        src_lvl,
   input  logic                 bus_valid,
   input  logic                 bus_write,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic [NCTX-1:0]      irq_o
);
   localparam int IDW = $clog2(NSRC + 1);

   if (NSRC < 1 || NSRC > 31) begin : g_bad_nsrc
      $error("intc_core: NSRC must lie in 1..31");
   end
   if (NCTX < 1 || NCTX > 32) begin : g_bad_nctx
      $error("intc_core: NCTX must lie in 1..32");
   end
   if (PW < 1 || PW > 8) begin : g_bad_pw
      $error("intc_core: PW must lie in 1..8");
   end

   logic [NSRC:0]              lvl, pend, busy;
   logic [NSRC:0][PW-1:0]      prio_q;
   logic [NCTX-1:0][NSRC:0]    en_q;
   logic [NCTX-1:0][PW-1:0]    thr_q;
   logic [NCTX-1:0][IDW-1:0]   best_id;
   logic                       claim_vld, done_vld;
   logic [IDW-1:0]             claim_id, done_id;

   assign lvl = {src_lvl, 1'b0};

   intc_gate #(.NSRC(NSRC), .IDW(IDW)) u_gate (
      .clk(clk), .rst_n(rst_n), .lvl(lvl),
      .claim_vld(claim_vld), .claim_id(claim_id),
      .done_vld(done_vld), .done_id(done_id),
      .pend(pend), .busy(busy)
   );

   intc_regbank #(.NSRC(NSRC), .NCTX(NCTX), .PW(PW), .IDW(IDW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .best_id(best_id), .busy(busy),
      .prio_q(prio_q), .en_q(en_q), .thr_q(thr_q),
      .claim_vld(claim_vld), .claim_id(claim_id),
      .done_vld(done_vld), .done_id(done_id)
   );

   for (genvar c = 0; c < NCTX; c++) begin : g_pick
      intc_pick #(.NSRC(NSRC), .PW(PW), .IDW(IDW)) u_pick (
         .clk(clk), .rst_n(rst_n),
         .pend(pend), .en(en_q[c]), .prio(prio_q), .thr(thr_q[c]),
         .best_id(best_id[c]), .irq_o(irq_o[c])
      );
   end
endmodule

// File: rtl/intc_core_chk.sv
`timescale 1ns/1ps
module intc_core_chk #(
   parameter int NSRC = 31,
   parameter int IDW  = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NSRC:0]   pend,
   input logic [NSRC:0]   busy,
   input logic            claim_vld,
   input logic [IDW-1:0]  claim_id,
   input logic            done_vld,
   input logic [IDW-1:0]  done_id,
   input logic [31:0]     bus_rdata
);
   assert_id0_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !pend[0] && !busy[0]);

   assert_claim_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      claim_vld |=> busy[$past(claim_id)] && !pend[$past(claim_id)]);

   assert_no_pend_in_flight_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend & busy) == '0);

   assert_done_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_vld |=> !busy[$past(done_id)]);

   assert_claim_returns_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
      claim_vld |=> bus_rdata == 32'($past(claim_id)));
endmodule

bind intc_core intc_core_chk #(.NSRC(NSRC), .IDW(IDW)) u_chk (
   .clk(clk), .rst_n(rst_n), .pend(pend), .busy(busy),
   .claim_vld(claim_vld), .claim_id(claim_id),
   .done_vld(done_vld), .done_id(done_id), .bus_rdata(bus_rdata)
);

// File: tb/test_intc_core.sv
`timescale 1ns/1ps
module test_intc_core;
   localparam int NSRC = 31;
   localparam int NCTX = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC:1]   src = '0;
   logic            bus_valid = 1'b0;
   logic            bus_write = 1'b0;
   logic [21:0]     bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [NCTX-1:0] irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit fin = 1'b0;

   always #10 clk = ~clk;

   intc_core #(.NSRC(NSRC), .NCTX(NCTX), .PW(3)) i_intc_core (
      .clk(clk), .rst_n(rst_n), .src_lvl(src),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq)
   );

   function automatic logic [21:0] a_prio(int s); return 22'(4 * s); endfunction
   function automatic logic [21:0] a_en(int c);   return 22'(32'h2000 + 32'h80 * c); endfunction
   function automatic logic [21:0] a_thr(int c);  return 22'(32'h200000 + 32'h1000 * c); endfunction
   function automatic logic [21:0] a_clm(int c);  return 22'(32'h200004 + 32'h1000 * c); endfunction

   // {source mask (bit k-1 = source k), expected claimed id}
   localparam logic [15:0] VEC [8] = '{
      {8'h48, 8'd0}, {8'h09, 8'd1}, {8'h06, 8'd2}, {8'hA4, 8'd3},
      {8'h13, 8'd5}, {8'hA0, 8'd8}, {8'h21, 8'd6}, {8'h00, 8'd0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [21:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic rd(input logic [21:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_valid = 1'b0;
      d = bus_rdata;
   endtask

   task automatic pulse(input int s);
      @(negedge clk); src[s] = 1'b1;
      @(negedge clk); src[s] = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!fin) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(1);

      // R9: reset state
      chk("R9 irq", 32'(irq), 32'h0);
      rd(a_clm(0), d);  chk("R9 claim", d, 0);
      rd(a_prio(5), d); chk("R9 prio", d, 0);
      rd(a_en(1), d);   chk("R9 enable", d, 0);
      rd(a_thr(1), d);  chk("R9 threshold", d, 0);

      // R1, R11: priority width and source 0
      wr(a_prio(9), 32'hFFFF_FFFF); rd(a_prio(9), d); chk("R1 prio width", d, 7);
      wr(a_prio(0), 32'h7);         rd(a_prio(0), d); chk("R11 prio id0", d, 0);
      // R2, R11: enable layout, bit 0 stays zero
      wr(a_en(1), 32'hFFFF_FFFF);   rd(a_en(1), d);   chk("R2 R11 enable", d, 32'hFFFF_FFFE);
      // R3: threshold width
      wr(a_thr(1), 32'hFFFF_FFFF);  rd(a_thr(1), d);  chk("R3 threshold", d, 7);

      // Table: context 0, sources 1..8, threshold 1
      wr(a_prio(1), 2); wr(a_prio(2), 5); wr(a_prio(3), 5); wr(a_prio(4), 1);
      wr(a_prio(5), 7); wr(a_prio(6), 3); wr(a_prio(7), 0); wr(a_prio(8), 4);
      wr(a_en(0), 32'h1FE); wr(a_thr(0), 1);
      for (int v = 0; v < 8; v++) begin
         @(negedge clk); src[8:1] = VEC[v][15:8];
         @(negedge clk); src[8:1] = '0;
         idle(2);
         chk("R4 irq per vector", 32'(irq[0]), 32'(VEC[v][7:0] != 0));
         rd(a_clm(0), d);
         chk("R5 winner", d, 32'(VEC[v][7:0]));
         for (int k = 0; k < 8; k++) begin
            if (d == 0) break;
            wr(a_clm(0), d);
            rd(a_clm(0), d);
         end
      end
      // R4: source 4 (prio 1) was held back by threshold 1; threshold 0 frees it
      idle(2);
      chk("R4 equal prio blocked", 32'(irq[0]), 0);
      wr(a_thr(0), 0); idle(2);
      chk("R4 above thr irq", 32'(irq[0]), 1);
      rd(a_clm(0), d); chk("R4 above thr claim", d, 4);
      wr(a_clm(0), 4); idle(2);
      chk("R1 prio zero never selected", 32'(irq[0]), 0);

      // Context 1: sources 9, 10, 11
      wr(a_prio(9), 4); wr(a_prio(10), 3); wr(a_prio(11), 6);
      wr(a_en(1), 32'h0E00); wr(a_thr(1), 2);

      // R6: held input, claimed source blocked
      @(negedge clk); src[9] = 1'b1;
      idle(2);
      chk("R4 irq ctx1", 32'(irq[1]), 1);
      rd(a_clm(1), d); chk("R6 claim 9", d, 9);
      idle(2);
      chk("R6 irq drops", 32'(irq[1]), 0);
      rd(a_clm(1), d); chk("R6 no reclaim", d, 0);
      // R7: wrong id, and id not enabled for context 0
      wr(a_clm(1), 10); idle(2);
      rd(a_clm(1), d); chk("R7 wrong id ignored", d, 0);
      wr(a_clm(0), 9);  idle(2);
      chk("R7 foreign ctx irq", 32'(irq[1]), 0);
      rd(a_clm(1), d); chk("R7 foreign ctx ignored", d, 0);
      // R8: complete with input still high
      wr(a_clm(1), 9); idle(2);
      chk("R8 irq again", 32'(irq[1]), 1);
      rd(a_clm(1), d); chk("R8 reclaim", d, 9);
      @(negedge clk); src[9] = 1'b0;
      wr(a_clm(1), 9); idle(2);
      chk("R8 quiet after low", 32'(irq[1]), 0);

      // R10: single-cycle pulse latched
      pulse(10); idle(4);
      rd(a_clm(1), d); chk("R10 pulse latched", d, 10);
      wr(a_clm(1), 10);

      // Same cycle: claim read while a higher source rises
      pulse(9); idle(2);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a_clm(1); src[11] = 1'b1;
      @(negedge clk);
      bus_valid = 1'b0; src[11] = 1'b0; d = bus_rdata;
      chk("R5 claim vs new input", d, 9);
      idle(1);
      rd(a_clm(1), d); chk("R5 late source", d, 11);
      wr(a_clm(1), 9); wr(a_clm(1), 11);

      // R4: priority equal to threshold
      wr(a_prio(10), 2);
      pulse(10); idle(3);
      chk("R4 equal irq", 32'(irq[1]), 0);
      rd(a_clm(1), d); chk("R4 equal claim", d, 0);
      wr(a_thr(1), 1); idle(2);
      chk("R4 lowered thr irq", 32'(irq[1]), 1);
      rd(a_clm(1), d); chk("R4 lowered thr claim", d, 10);
      wr(a_clm(1), 10); idle(2);
      chk("R7 release quiet", 32'(irq[1]), 0);

      fin = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule